// File: doc/BRIEF.md
# Serial Management Frame Engine

This block runs one management transaction on a two-wire serial management bus (MDC clock, bidirectional MDIO data) from a single 32-bit frame word. Software loads the whole transaction as one word: start bits, operation, PHY address, register address, turnaround code and 16 data bits. The engine sends a preamble of ones and then shifts the word out, most significant bit first. For a read, it releases the data line for the turnaround and the data phase, and it writes the 16 bits that come back into the low half of the same word.

A status output `idle` goes low when a frame is accepted and goes high again once the last bit period has ended. The bus clock is derived from the system clock by a divisor chosen with `div_sel`. The divisor is captured when the frame starts. An enable input gates the port: while it is low no frame starts, MDC stays low, and any frame in progress is dropped.

Top module: `mdio_frame_engine`

## Requirements
- R1: After reset, `idle` is 1, `mdc` is 0, `mdio_oe` is 0 and `frame_word` is 0. Whenever `idle` is 1, `mdc` and `mdio_oe` are 0.
- R2: A frame is 64 bit periods. Periods 0 to 31 drive a 1. Periods 32 to 63 drive `frame_word` bits 31 down to 0, so period p carries bit 63-p. The word layout is: bits 31:30 start (01), bits 29:28 operation (01 write, 10 read), bits 27:23 PHY address, bits 22:18 register address, bits 17:16 code (10), bits 15:0 data.
- R3: `div_sel` values 0,1,2,3,4,5 select divisors 8,16,32,48,64,96, and values 6 and 7 select 96. The value is sampled in the cycle the word is written. MDC is low for the first half of each period and high for the second half. Its first rising edge comes d/2 cycles after the write edge, and later rising edges come every d cycles.
- R4: `idle` is low for exactly 64·d cycles, starting at the clock edge that accepts the write.
- R5: For any operation other than 10, all 64 periods are driven (`mdio_oe`=1), including the code and data bits.
- R6: For operation 10, `mdio_oe` is 0 in periods 46 to 63. `mdio_i` is sampled at the rising MDC edge of periods 48 to 63 into bit 63-p. Bits 31:16 of the word are left unchanged.
- R7: While a frame runs, `mdio_o` changes only at the clock edge where MDC falls.
- R8: A write strobe while `idle` is 0 is ignored. The word, the frame bits and the frame length are unaffected.
- R9: With `en` low, a write strobe loads `frame_word`, but `idle` stays 1 and MDC stays 0. Raising `en` later does not start the frame.
- R10: If `en` is low at a clock edge, `idle` is 1 after that edge, and `mdc` and `mdio_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Management port enable |
| div_sel | input | 3 | MDC divisor select |
| wr_valid | input | 1 | Frame word write strobe |
| wr_data | input | 32 | Frame word to load |
| frame_word | output | 32 | Current frame word, holding read data after a read |
| idle | output | 1 | High when no frame is running |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
Internal faults show up at the ports in specific ways.

- **Slot counter off by one:** the frame length seen on `idle` changes by a whole bit period. The bits seen at the rising MDC edges shift by one period at the 32nd rising edge, which is where the preamble ends.
- **Wrong half-period count:** the first rising edge of MDC and the spacing between rising edges are wrong from the first period.
- **Wrong release window or capture index:** `mdio_oe` is wrong in period 46, or the returned read data is wrong as soon as the frame ends.

The sweep covers every divisor in both the write and the read direction.

// File: rtl/mdio_pkg.sv
// Shared constants and helpers for the management frame engine.
// Assumes a 32-bit frame word preceded by a 32-bit preamble.
package mdio_pkg;
    localparam int PRE_LEN = 32;
    localparam int WORD_W  = 32;
    localparam int DATA_W  = 16;
    localparam int SLOT_N  = PRE_LEN + WORD_W;
    localparam int IDX_W   = $clog2(SLOT_N);
    localparam int POS_W   = $clog2(WORD_W);
    localparam int HALF_W  = 7;
    localparam int OP_HI   = 29;
    localparam int OP_LO   = 28;
    localparam logic [1:0] OP_READ = 2'b10;

    // Map the divisor select to half of the MDC period, in system clocks.
    function automatic logic [HALF_W-1:0] half_of(input logic [2:0] sel);
        case (sel)
            3'd0:    half_of = HALF_W'(4);
            3'd1:    half_of = HALF_W'(8);
            3'd2:    half_of = HALF_W'(16);
            3'd3:    half_of = HALF_W'(24);
            3'd4:    half_of = HALF_W'(32);
            default: half_of = HALF_W'(48);
        endcase
    endfunction
endpackage

// File: rtl/mdio_clk_div.sv
// MDC generator. While run is high it toggles mdc every half period and
// flags the system-clock cycle just before each rising and falling edge.
// The half period is latched from sel while run is low, so a running
// frame keeps one rate. mdc is low whenever run is low.
module mdio_clk_div
    import mdio_pkg::*;
#(
    parameter int CW = HALF_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] sel,
    output logic       mdc,
    output logic       rise_tick,
    output logic       fall_tick
);
    logic [CW-1:0] half_q;
    logic [CW-1:0] cnt;
    logic          mdc_q;
    logic          at_end;

    assign at_end = (cnt == half_q - 1'b1);

    // Count half periods and toggle the management clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= CW'(4);
            cnt    <= '0;
            mdc_q  <= 1'b0;
        end else if (!run) begin
            half_q <= CW'(half_of(sel));
            cnt    <= '0;
            mdc_q  <= 1'b0;
        end else if (at_end) begin
            cnt    <= '0;
            mdc_q  <= ~mdc_q;
        end else begin
            cnt    <= cnt + 1'b1;
        end
    end

    assign mdc       = mdc_q;
    assign rise_tick = run && at_end && !mdc_q;
    assign fall_tick = run && at_end &&  mdc_q;
endmodule

// File: rtl/mdio_frame_shift.sv
// Frame sequencer. It holds the frame word, walks the 64 bit periods
// (preamble, then the word MSB first), releases the line for the
// turnaround and data of a read, and stores the sampled bits in place.
// Assumes rise_tick and fall_tick never fire in the same cycle.
module mdio_frame_shift
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_i,
    output logic [WORD_W-1:0] word,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam logic [IDX_W-1:0] TA_REL   = IDX_W'(WORD_W - DATA_W - 2);
    localparam logic [IDX_W-1:0] DATA_REL = IDX_W'(WORD_W - DATA_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOT_N - 1);

    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] rel;
    logic [POS_W-1:0] pos;
    logic             preamble;
    logic             is_rd;
    logic             released;
    logic             capture;

    // Decode where the current bit period sits in the frame.
    always_comb begin
        preamble = (idx < IDX_W'(PRE_LEN));
        rel      = idx - IDX_W'(PRE_LEN);
        pos      = POS_W'(WORD_W - 1) - rel[POS_W-1:0];
        is_rd    = (word[OP_HI:OP_LO] == OP_READ);
        released = is_rd && !preamble && (rel >= TA_REL);
        capture  = is_rd && !preamble && (rel >= DATA_REL);
    end

    // Accept words, advance the bit period and store read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
            busy <= 1'b0;
            idx  <= '0;
        end else if (!busy) begin
            if (wr_valid) begin
                word <= wr_data;
                busy <= en;
                idx  <= '0;
            end
        end else if (!en) begin
            busy <= 1'b0;
        end else begin
            if (rise_tick && capture)
                word[pos] <= mdio_i;
            if (fall_tick) begin
                if (idx == LAST_IDX)
                    busy <= 1'b0;
                else
                    idx <= idx + 1'b1;
            end
        end
    end

    // Drive the line only outside the released window.
    always_comb begin
        mdio_oe = busy && !released;
        mdio_o  = mdio_oe && (preamble || word[pos]);
    end
endmodule

// File: rtl/mdio_frame_engine.sv
// Top of the management frame engine: the MDC divider plus the frame
// sequencer. The sequencer's busy flag, gated by en, runs the divider.
// Assumes en, div_sel and the write strobe come from the clk domain.
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [2:0]        div_sel,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] frame_word,
    output logic              idle,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic busy;
    logic run;
    logic rise_tick;
    logic fall_tick;

    assign run  = busy && en;
    assign idle = !busy;

    mdio_clk_div #(.CW(HALF_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .sel       (div_sel),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .word      (frame_word),
        .busy      (busy),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );
endmodule

// File: rtl/mdio_frame_checker.sv
// Port-level properties of the management frame engine, bound to the top.
module mdio_frame_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        en,
    input logic        idle,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic [31:0] frame_word
);
    // R1: an idle port keeps the clock low and the line released
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!mdc && !mdio_oe));

    // R3: every MDC level lasts at least two system clocks
    a_r3_min_half: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdc) |=> $stable(mdc));

    // R7: data out moves only together with a falling MDC
    a_r7_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && $past(!idle) && !$fell(mdc)) |-> $stable(mdio_o));

    // R8: header fields hold while a frame runs
    a_r8_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && $past(!idle)) |-> $stable(frame_word[31:16]));

    // R10: a low enable leaves the engine idle after the edge
    a_r10_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> idle);
endmodule

bind mdio_frame_engine mdio_frame_checker i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .idle       (idle),
    .mdc        (mdc),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .frame_word (frame_word)
);

// File: tb/test_mdio_frame_engine.sv
// Sweeps every divisor select with write and read frames, and checks
// bits, timing and read-back against values computed from the requirements.
module test_mdio_frame_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [2:0]  div_sel = 3'd0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        mdio_i = 1'b1;
    logic [31:0] frame_word;
    logic        idle, mdc, mdio_o, mdio_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mdio_frame_engine i_mdio_frame_engine (
        .clk(clk), .rst_n(rst_n), .en(en), .div_sel(div_sel),
        .wr_valid(wr_valid), .wr_data(wr_data), .frame_word(frame_word),
        .idle(idle), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int divisor(input logic [2:0] s);
        case (s)
            3'd0: return 8;
            3'd1: return 16;
            3'd2: return 32;
            3'd3: return 48;
            3'd4: return 64;
            default: return 96;
        endcase
    endfunction

    function automatic logic [31:0] mkw(input logic [1:0] op, input logic [4:0] phy,
                                        input logic [4:0] rg, input logic [15:0] dat);
        return {2'b01, op, phy, rg, 2'b10, dat};
    endfunction

    // Run one frame and model the PHY; poke issues a write strobe mid-frame.
    task automatic run_frame(input logic [2:0] sel, input logic [31:0] w,
                             input logic [15:0] rd, input bit poke);
        int d = divisor(sel);
        int h = d / 2;
        bit is_rd = (w[29:28] == 2'b10);
        int cyc = 0, rc = 0, first = 0, second = 0, bad = 0, r7bad = 0;
        logic prev_mdc = 1'b0;
        logic prev_o = 1'b0;
        logic [31:0] exp_w;
        @(negedge clk);
        div_sel = sel; wr_data = w; wr_valid = 1'b1; mdio_i = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
        while (!idle && cyc < 7000) begin
            cyc++;
            if (poke && cyc == 20) begin wr_valid = 1'b1; wr_data = ~w; end
            if (poke && cyc == 21) wr_valid = 1'b0;
            if (cyc > 1 && mdio_o !== prev_o && !(prev_mdc && !mdc)) r7bad++;
            if (mdc && !prev_mdc) begin
                bit eoe = !(is_rd && rc >= 46);
                logic eo = (rc < 32) ? 1'b1 : w[63 - rc];
                if (eoe) begin
                    if (mdio_oe !== 1'b1 || mdio_o !== eo) bad++;
                end else if (mdio_oe !== 1'b0) bad++;
                if (rc == 0) first = cyc;
                if (rc == 1) second = cyc;
                rc++;
                mdio_i = (rc >= 48 && rc < 64) ? rd[63 - rc] : 1'b1;
            end
            prev_mdc = mdc;
            prev_o = mdio_o;
            @(negedge clk);
        end
        exp_w = is_rd ? {w[31:16], rd} : w;
        check(cyc == 64 * d, "R4", "idle low cycles", cyc, 64 * d);
        check(first == h + 1 && second - first == d, "R3", "mdc first rise / period",
              {32'(first), 32'(second - first)}, {32'(h + 1), 32'(d)});
        check(bad == 0 && rc == 64, is_rd ? "R6" : "R5", "bad bit periods / count",
              {32'(bad), 32'(rc)}, {32'd0, 32'd64});
        check(r7bad == 0, "R7", "mdio_o changes away from mdc fall", r7bad, 0);
        check(frame_word == exp_w, is_rd ? "R6" : "R2", "word after frame", frame_word, exp_w);
        if (poke) check(frame_word == exp_w && bad == 0, "R8", "write while busy", frame_word, exp_w);
    endtask

    initial begin
        #(8 * 190000);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        if (!done) $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(idle === 1'b1 && mdc === 1'b0 && mdio_oe === 1'b0 && frame_word === 32'h0,
              "R1", "reset state", {idle, mdc, mdio_oe, frame_word}, {3'b100, 32'h0});
        en = 1'b1;

        // R2 R5 R6: sweep every divisor in both directions
        for (int s = 0; s < 6; s++) begin
            run_frame(3'(s), mkw(2'b01, 5'(s * 5 + 1), 5'(31 - s * 3), 16'(16'hA5C3 ^ (s * 16'h1111))),
                      16'h0, 1'b0);
            run_frame(3'(s), mkw(2'b10, 5'(s + 16), 5'(s * 2), 16'h0),
                      16'(16'h8001 + s * 16'h0F3B), 1'b0);
        end
        run_frame(3'd7, mkw(2'b10, 5'd31, 5'd31, 16'hFFFF), 16'h5AA5, 1'b0);
        run_frame(3'd6, mkw(2'b01, 5'd0, 5'd0, 16'h0000), 16'h0, 1'b0);
        // R8: a strobe in mid-frame must be ignored
        run_frame(3'd0, mkw(2'b01, 5'd9, 5'd3, 16'h1234), 16'h0, 1'b1);

        // R10: dropping enable aborts a running frame
        @(negedge clk);
        div_sel = 3'd1; wr_data = mkw(2'b01, 5'd2, 5'd4, 16'hBEEF); wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
        repeat (100) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check(idle === 1'b1 && mdc === 1'b0 && mdio_oe === 1'b0, "R10", "abort state",
              {idle, mdc, mdio_oe}, 3'b100);

        // R9: a write with enable low loads the word but runs no frame
        begin
            int seen = 0;
            @(negedge clk);
            wr_data = mkw(2'b10, 5'd7, 5'd8, 16'hC0DE); wr_valid = 1'b1;
            @(negedge clk);
            wr_valid = 1'b0;
            for (int i = 0; i < 200; i++) begin
                if (!idle || mdc) seen++;
                @(negedge clk);
            end
            en = 1'b1;
            for (int i = 0; i < 50; i++) begin
                if (!idle || mdc) seen++;
                @(negedge clk);
            end
            check(seen == 0, "R9", "activity with enable low", seen, 0);
            check(frame_word == mkw(2'b10, 5'd7, 5'd8, 16'hC0DE), "R9", "word loaded",
                  frame_word, mkw(2'b10, 5'd7, 5'd8, 16'hC0DE));
        end

        // Engine still works after the abort
        run_frame(3'd2, mkw(2'b10, 5'd1, 5'd1, 16'h0), 16'h0F0F, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule